// File: doc/BRIEF.md
# Self-Synchronising PRBS Word Checker with Decimal Error Tally

This block sits behind a deserialiser and checks received parallel words against the pseudo-random sequence the far end is known to transmit. Each lane delivers one word per clock. A single shared qualifier marks the cycles that carry data. Every lane runs its own local copy of the sequence generator. That copy needs no out-of-band seed, because the first qualified word after reset loads it. From the next qualified word on, the block compares each received word with the expected one.

A mismatch on any lane produces a sticky error flag and one step of a decimal tally. The tally is built from chained 4-bit BCD digits and can drive a numeric display directly. It advances once for every clock that carries an errored comparison and wraps from all nines back to zero. Three status bits report the link state: data is being received, the data so far is correct, and an error has occurred. Cycles without the qualifier are invisible to the checker.

Top module: `prbs_word_checker`

## Requirements
- R1: The first cycle with `rx_valid_i` high after reset loads each lane's generator from that lane's word and performs no comparison. `match_o` keeps its reset value 0, and no error is recorded for that word.
- R2: Each later qualified word is compared against the next word of the sequence s[n] = s[n-7] XOR s[n-6]. Bit 7 of a word is the earliest bit in time. Lane l occupies `rx_data_i[8l+7:8l]`. `match_o` is updated one clock after the word is sampled and is 1 only when every lane matched.
- R3: The local generator advances along its own expected sequence and does not follow the received data. A single corrupted word therefore yields one mismatch, and the next correct word matches again.
- R4: `err_flag_o` goes high one clock after `match_o` has been updated to 0 by a comparison. It stays high until reset.
- R5: The tally increases by exactly one per clock that carries a failed comparison, so consecutive errored words each count. It changes on no other cycle.
- R6: The tally is presented as decimal digits. `err_bcd_o[3:0]` holds the ones digit and `err_bcd_o[7:4]` the tens digit. Each digit stays in 0..9, and the ones digit carries into the tens digit when it steps from 9 to 0.
- R7: An error counted while the tally reads 99 returns it to 00, and counting continues from there.
- R8: Cycles with `rx_valid_i` low do not seed, compare or advance the generators. They change neither `match_o`, the flag nor the tally, whatever `rx_data_i` carries.
- R9: `status_o[0]` (receiving) goes high one clock after the first matching comparison and stays high. `status_o[1]` (correct) equals `status_o[0]` AND NOT the error flag. `status_o[2]` (error) mirrors the error flag.
- R10: Reset clears the flag, the tally, `match_o`, all status bits and the seeded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_data_i | input | LANES*WORD_W (16) | Received words, lane l at bits [8l+7:8l] |
| rx_valid_i | input | 1 | Qualifier: the words on rx_data_i are data |
| match_o | output | 1 | Result of the most recent comparison |
| err_flag_o | output | 1 | Sticky error flag |
| err_bcd_o | output | DIGITS*4 (8) | Error tally as BCD, ones digit lowest |
| status_o | output | 3 | {error, correct, receiving} |

## Verification
The assertions check four things on every cycle:
- the flag never falls once set, and it follows every failed comparison;
- no BCD digit leaves 0..9, and an all-nines carry lands on zero;
- unqualified cycles leave the comparison result and the seeded state untouched, and the tally moves only on an error cycle;
- the receiving status never precedes seeding.

Only the bench's scenarios can show that the expected sequence is the right polynomial and bit order and that a single bad word costs exactly one count. The same holds for the exact decimal values through a full sweep to 99 and the wrap, the ordering of the status bits around the first error, and the clearing by a mid-run reset.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

   // Status word presented at the top-level port, MSB first.
   typedef struct packed {
      logic err;    // sticky error present
      logic good;   // receiving and no error seen
      logic rx;     // at least one matching word after seeding
   } chk_status_t;

   localparam int unsigned BCD_W = 4;

endpackage

// File: rtl/prbs_lane_gen.sv
// One lane: expected-sequence generator plus word comparator.
module prbs_lane_gen #(
   parameter int unsigned WORD_W    = 8,
   parameter int unsigned PRBS_ORDER = 7,
   parameter int unsigned PRBS_TAP   = 6
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              eq_o
);

   logic [PRBS_ORDER-1:0] hist_q;
   logic [WORD_W-1:0]     exp_w;

   // hist_q[0] is the newest serial bit, hist_q[k] is k+1 bits back.
   always_comb begin : gen_word
      logic [PRBS_ORDER-1:0] h;
      logic                  b;
      h     = hist_q;
      exp_w = '0;
      for (int i = 0; i < int'(WORD_W); i++) begin
         b = h[PRBS_ORDER-1] ^ h[PRBS_TAP-1];
         h = {h[PRBS_ORDER-2:0], b};
         exp_w[WORD_W-1-i] = b;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hist_q <= '0;
      end else if (load_i) begin
         hist_q <= word_i[PRBS_ORDER-1:0];
      end else if (adv_i) begin
         hist_q <= exp_w[PRBS_ORDER-1:0];
      end
   end

   assign eq_o = (word_i == exp_w);

   // R8: an unqualified cycle leaves the generator where it was.
   assert_hold_when_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && !adv_i) |=> $stable(hist_q));

endmodule

// File: rtl/bcd_digit.sv
// One decade of the decimal tally.
module bcd_digit
   import prbs_chk_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             inc_i,
   output logic [BCD_W-1:0] val_o,
   output logic             carry_o
);

   logic [BCD_W-1:0] val_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         val_q <= '0;
      end else if (inc_i) begin
         val_q <= (val_q == BCD_W'(9)) ? '0 : val_q + BCD_W'(1);
      end
   end

   assign val_o   = val_q;
   assign carry_o = inc_i && (val_q == BCD_W'(9));

   assert_digit_range_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      val_q <= BCD_W'(9));

endmodule

// File: rtl/bcd_counter.sv
// Chain of decades; the tally wraps from all nines to zero.
module bcd_counter
   import prbs_chk_pkg::*;
#(
   parameter int unsigned DIGITS = 2
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    inc_i,
   output logic [DIGITS*BCD_W-1:0] count_o
);

   logic [DIGITS:0] carry;

   assign carry[0] = inc_i;

   for (genvar d = 0; d < int'(DIGITS); d++) begin : g_dec
      bcd_digit u_dig (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .inc_i  (carry[d]),
         .val_o  (count_o[d*BCD_W +: BCD_W]),
         .carry_o(carry[d+1])
      );
   end

   // R7: a carry out of the top decade means the tally returns to zero.
   assert_wrap_to_zero_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      carry[DIGITS] |=> (count_o == '0));

   // R5: a single error step never skips past a value.
   assert_single_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (inc_i && !carry[DIGITS]) |=> (count_o != $past(count_o)));

endmodule

// File: rtl/prbs_word_checker.sv
module prbs_word_checker
   import prbs_chk_pkg::*;
#(
   parameter int unsigned LANES      = 2,
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned PRBS_ORDER = 7,
   parameter int unsigned PRBS_TAP   = 6,
   parameter int unsigned DIGITS     = 2,
   localparam int unsigned DATA_W    = LANES * WORD_W,
   localparam int unsigned CNT_W     = DIGITS * BCD_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_valid_i,
   output logic              match_o,
   output logic              err_flag_o,
   output logic [CNT_W-1:0]  err_bcd_o,
   output logic [2:0]        status_o
);

   // Elaboration-time parameter checks.
   if (LANES < 1) begin : g_chk_lanes
      $error("LANES must be at least 1");
   end
   if (PRBS_ORDER < 2 || PRBS_ORDER > WORD_W) begin : g_chk_order
      $error("PRBS_ORDER must lie in 2..WORD_W so one word can seed it");
   end
   if (PRBS_TAP < 1 || PRBS_TAP >= PRBS_ORDER) begin : g_chk_tap
      $error("PRBS_TAP must lie in 1..PRBS_ORDER-1");
   end
   if (DIGITS < 1) begin : g_chk_digits
      $error("DIGITS must be at least 1");
   end

   logic             seeded_q;
   logic             cmp_fire_q;
   logic             match_q;
   logic             err_q;
   logic             rxok_q;
   logic [LANES-1:0] lane_eq;
   logic             load;
   logic             adv;
   logic             err_evt;
   chk_status_t      stat;

   assign load = rx_valid_i && !seeded_q;
   assign adv  = rx_valid_i && seeded_q;

   for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
      prbs_lane_gen #(
         .WORD_W    (WORD_W),
         .PRBS_ORDER(PRBS_ORDER),
         .PRBS_TAP  (PRBS_TAP)
      ) u_lane (
         .clk_i (clk_i),
         .rst_i (rst_i),
         .load_i(load),
         .adv_i (adv),
         .word_i(rx_data_i[l*WORD_W +: WORD_W]),
         .eq_o  (lane_eq[l])
      );
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         seeded_q   <= 1'b0;
         cmp_fire_q <= 1'b0;
         match_q    <= 1'b0;
         err_q      <= 1'b0;
         rxok_q     <= 1'b0;
      end else begin
         cmp_fire_q <= adv;
         if (load) begin
            seeded_q <= 1'b1;
         end
         if (adv) begin
            match_q <= &lane_eq;
         end
         if (err_evt) begin
            err_q <= 1'b1;
         end
         if (cmp_fire_q && match_q) begin
            rxok_q <= 1'b1;
         end
      end
   end

   assign err_evt = cmp_fire_q && !match_q;

   bcd_counter #(
      .DIGITS(DIGITS)
   ) u_tally (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .inc_i  (err_evt),
      .count_o(err_bcd_o)
   );

   assign stat.err   = err_q;
   assign stat.good  = rxok_q && !err_q;
   assign stat.rx    = rxok_q;
   assign status_o   = stat;
   assign match_o    = match_q;
   assign err_flag_o = err_q;

   assert_sticky_flag_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      err_q |=> err_q);

   assert_flag_after_miss_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmp_fire_q && !match_q) |=> err_q);

   assert_idle_no_effect_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !rx_valid_i |=> ($stable(match_q) && $stable(seeded_q)));

   assert_tally_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      !err_evt |=> $stable(err_bcd_o));

   assert_seed_no_compare_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      load |=> !cmp_fire_q);

   assert_rx_needs_seed_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      rxok_q |-> seeded_q);

endmodule

// File: tb/sim_prbs_word_checker.sv
module sim_prbs_word_checker;

   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 2;
   localparam int WORD_W     = 8;
   localparam int DATA_W     = LANES * WORD_W;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [DATA_W-1:0] data = '0;
   logic              vld = 1'b0;
   logic              match;
   logic              err_flag;
   logic [7:0]        bcd;
   logic [2:0]        status;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [6:0] src [LANES];

   always #(CLK_PERIOD/2) clk = ~clk;

   prbs_word_checker u0 (
      .clk_i     (clk),
      .rst_i     (rst),
      .rx_data_i (data),
      .rx_valid_i(vld),
      .match_o   (match),
      .err_flag_o(err_flag),
      .err_bcd_o (bcd),
      .status_o  (status)
   );

   // Transmitter model: serial s[n] = s[n-7]^s[n-6], earliest bit in word bit 7.
   task automatic next_words(output logic [DATA_W-1:0] d);
      d = '0;
      for (int l = 0; l < LANES; l++) begin
         for (int b = 0; b < WORD_W; b++) begin
            logic nb;
            nb = src[l][6] ^ src[l][5];
            src[l] = {src[l][5:0], nb};
            d[l*WORD_W + WORD_W-1-b] = nb;
         end
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int to_bcd(input int n);
      return ((n / 10) << 4) | (n % 10);
   endfunction

   task automatic cyc(input logic v, input logic [DATA_W-1:0] d);
      @(negedge clk);
      vld  = v;
      data = d;
      @(posedge clk);
      #1;
   endtask

   task automatic send_good();
      logic [DATA_W-1:0] w;
      next_words(w);
      cyc(1'b1, w);
   endtask

   task automatic send_bad(input int lane);
      logic [DATA_W-1:0] w;
      next_words(w);
      w[lane*WORD_W +: WORD_W] = w[lane*WORD_W +: WORD_W] ^ 8'h81;
      cyc(1'b1, w);
   endtask

   task automatic idle();
      cyc(1'b0, 16'hA55A);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      src[0] = 7'h01;
      src[1] = 7'h55;
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset match", int'(match), 0);
      chk("R10 reset flag", int'(err_flag), 0);
      chk("R10 reset tally", int'(bcd), 0);
      chk("R10 reset status", int'(status), 0);
      @(negedge clk);
      rst = 1'b0;

      // R8: garbage with valid low before seeding does nothing
      idle();
      idle();
      chk("R8 no seed while idle", int'(status), 0);

      // R1: seed word, no comparison
      send_good();
      chk("R1 seed no compare", int'(match), 0);
      idle();
      chk("R1 seed no error", int'(err_flag), 0);
      chk("R1 seed no receiving", int'(status), 0);

      // R2: following words match
      send_good();
      chk("R2 first compare", int'(match), 1);
      idle();
      chk("R9 receiving and correct", int'(status), 3);
      for (int i = 0; i < 20; i++) begin
         send_good();
         chk("R2 stream match", int'(match), 1);
      end

      // R8: gaps carrying garbage neither advance nor compare
      for (int i = 0; i < 5; i++) begin
         idle();
         chk("R8 gap match held", int'(match), 1);
      end
      for (int i = 0; i < 4; i++) begin
         send_good();
         chk("R8 stream after gap", int'(match), 1);
      end
      idle();
      chk("R8 no error from gaps", int'(err_flag), 0);
      chk("R8 tally untouched", int'(bcd), 0);

      // R3/R4: single corrupted word on lane 1
      send_bad(1);
      chk("R2 mismatch lane1", int'(match), 0);
      chk("R4 flag not yet", int'(err_flag), 0);
      send_good();
      chk("R3 resync next word", int'(match), 1);
      chk("R4 flag set", int'(err_flag), 1);
      chk("R5 one count", int'(bcd), to_bcd(1));
      chk("R9 error status", int'(status), 5);
      idle();
      chk("R5 single error one count", int'(bcd), to_bcd(1));
      for (int i = 0; i < 3; i++) begin
         idle();
         chk("R8 idle tally held", int'(bcd), to_bcd(1));
      end
      send_good();
      idle();
      chk("R4 flag sticky", int'(err_flag), 1);

      // R5: burst of consecutive errors on lane 0
      for (int i = 0; i < 5; i++) send_bad(0);
      idle();
      chk("R5 burst counted per cycle", int'(bcd), to_bcd(6));

      // R6: sweep to 99, checking every decimal value
      for (int i = 0; i < 93; i++) begin
         send_bad(i % 2);
         chk("R6 decimal tally", int'(bcd), to_bcd(6 + i));
      end
      idle();
      chk("R6 tally at 99", int'(bcd), to_bcd(99));

      // R7: wrap
      send_bad(0);
      idle();
      chk("R7 wrap to 00", int'(bcd), 0);
      send_bad(1);
      idle();
      chk("R7 continue after wrap", int'(bcd), to_bcd(1));

      // R10: reset mid-run
      @(negedge clk);
      rst = 1'b1;
      vld = 1'b0;
      @(posedge clk);
      #1;
      chk("R10 flag cleared", int'(err_flag), 0);
      chk("R10 tally cleared", int'(bcd), 0);
      chk("R10 status cleared", int'(status), 0);
      chk("R10 match cleared", int'(match), 0);
      @(negedge clk);
      rst = 1'b0;
      send_good();
      chk("R1 reseed no compare", int'(match), 0);
      send_good();
      chk("R1 reseed then match", int'(match), 1);
      idle();
      chk("R9 receiving after reseed", int'(status), 3);
      chk("R1 no error after reseed", int'(bcd), 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule